// File: doc/BRIEF.md
# 3D Workgroup Dispatch Sequencer

This block steps through a three-dimensional grid of workgroups for a single kernel launch. A launch pulse loads grid and workgroup sizes for X, Y and Z. An iterative divider then works out how many workgroups each axis holds, rounding up so that partial workgroups at the edges are included. A multiply stage forms the total workgroup count. Until that arithmetic is finished, `ready_o` stays low and dispatch requests have no effect.

Once ready, the block presents the coordinates of the next workgroup and its flat index. Each accepted dispatch pulse moves the walk forward by one workgroup, with X changing fastest. When Z runs past its last workgroup, a sticky flag marks the grid as fully issued. Completion notices for finished workgroups are counted separately. The launch is finished when the grid is fully issued and the count of completion notices equals the total.

Top module: `wg_dispatch_seq`

## Requirements
- R1: After launch, `wg_count_o[d]` equals ceil(grid_size[d] / wg_size[d]) for each axis d (index 0 = X, 1 = Y, 2 = Z) once `ready_o` is high.
- R2: Once `ready_o` is high, `total_wg_o` equals the product of the three per-axis counts.
- R3: `ready_o` is low in the cycle after a launch and stays low until the counts are valid. A dispatch pulse while `ready_o` is low changes nothing.
- R4: After reset or launch, the three IDs, `global_id_o`, `completed_o` and `dispatch_complete_o` are all zero, and `all_done_o` is low.
- R5: A dispatch is accepted when `dispatch_i` is high, `ready_o` is high and `dispatch_complete_o` is low. Each accepted dispatch adds one to `global_id_o` on the next cycle.
- R6: An accepted dispatch adds one to the X ID. When (X+1)·wg_size_x ≥ grid_size_x, X returns to 0 and Y steps instead. Y carries into Z by the same rule.
- R7: When Z steps to a value whose product with wg_size_z reaches or passes grid_size_z, `dispatch_complete_o` rises. It stays high until the next launch.
- R8: Dispatch pulses while `dispatch_complete_o` is high leave all IDs and `global_id_o` unchanged.
- R9: Each cycle with `wg_done_i` high adds one to `completed_o`.
- R10: `all_done_o` is high exactly when `dispatch_complete_o` is high and `completed_o` equals `total_wg_o`.
- R11: A launch in the middle of a walk discards the walk in progress, clears all counters and flags, and restarts with the new sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Load sizes and clear state |
| grid_size_i | input | 3×SIZE_W | Grid size per axis, [0]=X |
| wg_size_i | input | 3×SIZE_W | Workgroup size per axis, never zero |
| dispatch_i | input | 1 | Request to issue the current workgroup |
| wg_done_i | input | 1 | One workgroup finished |
| ready_o | output | 1 | Counts valid, dispatch enabled |
| wg_id_o | output | 3×SIZE_W | Current workgroup ID per axis |
| global_id_o | output | 3×SIZE_W | Flat index of current workgroup |
| wg_count_o | output | 3×SIZE_W | Workgroups per axis |
| total_wg_o | output | 3×SIZE_W | Total workgroups |
| dispatch_complete_o | output | 1 | Whole grid issued (sticky) |
| completed_o | output | 3×SIZE_W | Completion notices counted |
| all_done_o | output | 1 | Launch finished |

## Verification
The hardest situation to reach from the ports is a carry that ripples through both Y and Z in a single cycle. That needs axis sizes that leave partial edge workgroups and counts above one on every axis. The bench sweeps every combination of five (grid, workgroup) pairs per axis, including exact fits, partial edges and single-workgroup axes. It walks each resulting grid to the end against an arithmetic model and then sends extra dispatches after completion. One further launch is issued midway through a walk, after some dispatches and notices have been counted, to show that the restart clears everything.

// File: rtl/wg_seq_pkg.sv
package wg_seq_pkg;
  localparam int NDIM = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DIV,
    PH_MUL_XY,
    PH_MUL_Z,
    PH_RDY
  } calc_phase_e;
endpackage

// File: rtl/wg_ceil_div.sv
module wg_ceil_div #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         busy_o
);
  localparam int NW = W + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] quo_q, rem_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  logic [NW:0]   shifted;
  logic          ge;
  logic [NW:0]   diff;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign ge      = shifted >= {2'b00, den_q};
  assign diff    = shifted - {2'b00, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      // ceil(n/d) = floor((n + d - 1) / d)
      quo_q  <= {1'b0, num_i} + {1'b0, den_i} - NW'(1);
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CW'(NW);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q  <= ge ? diff[NW-1:0] : shifted[NW-1:0];
      quo_q  <= {quo_q[NW-2:0], ge};
      cnt_q  <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q[W-1:0];
  assign busy_o = busy_q;
endmodule

// File: rtl/wg_count_calc.sv
module wg_count_calc
  import wg_seq_pkg::*;
#(
  parameter int SIZE_W = 16,
  localparam int TOT_W = NDIM * SIZE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        launch_i,
  input  logic [NDIM-1:0][SIZE_W-1:0] grid_size_i,
  input  logic [NDIM-1:0][SIZE_W-1:0] wg_size_i,
  output logic [NDIM-1:0][SIZE_W-1:0] count_o,
  output logic [TOT_W-1:0]            total_o,
  output logic                        ready_o
);
  localparam int PW = 2 * SIZE_W;

  logic [NDIM-1:0] busy;
  calc_phase_e     phase_q;
  logic [PW-1:0]   p_xy_q;
  logic [TOT_W-1:0] total_q;

  for (genvar d = 0; d < NDIM; d++) begin : g_div
    wg_ceil_div #(.W(SIZE_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(launch_i),
      .num_i  (grid_size_i[d]),
      .den_i  (wg_size_i[d]),
      .quo_o  (count_o[d]),
      .busy_o (busy[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      p_xy_q  <= '0;
      total_q <= '0;
    end else if (launch_i) begin
      phase_q <= PH_DIV;
    end else begin
      unique case (phase_q)
        PH_DIV: if (busy == '0) phase_q <= PH_MUL_XY;
        PH_MUL_XY: begin
          p_xy_q  <= PW'(count_o[0]) * PW'(count_o[1]);
          phase_q <= PH_MUL_Z;
        end
        PH_MUL_Z: begin
          total_q <= TOT_W'(p_xy_q) * TOT_W'(count_o[2]);
          phase_q <= PH_RDY;
        end
        default: ;
      endcase
    end
  end

  assign total_o = total_q;
  assign ready_o = (phase_q == PH_RDY);
endmodule

// File: rtl/wg_id_walker.sv
module wg_id_walker
  import wg_seq_pkg::*;
#(
  parameter int SIZE_W = 16,
  localparam int TOT_W = NDIM * SIZE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        launch_i,
  input  logic                        adv_i,
  input  logic [NDIM-1:0][SIZE_W-1:0] count_i,
  output logic [NDIM-1:0][SIZE_W-1:0] id_o,
  output logic [TOT_W-1:0]            gid_o,
  output logic                        complete_o
);
  logic [SIZE_W-1:0] id_q [NDIM];
  logic [NDIM-1:0]   wrap, step;
  logic [TOT_W-1:0]  gid_q;
  logic              complete_q;

  // (id+1)*size >= grid  <=>  id+1 >= ceil(grid/size)
  for (genvar d = 0; d < NDIM; d++) begin : g_axis
    localparam bit LAST = (d == NDIM - 1);

    assign wrap[d] = ({1'b0, id_q[d]} + 1'b1) >= {1'b0, count_i[d]};

    if (d == 0) begin : g_first
      assign step[d] = adv_i;
    end else begin : g_next
      assign step[d] = step[d-1] & wrap[d-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          id_q[d] <= '0;
      else if (launch_i)    id_q[d] <= '0;
      else if (step[d]) begin
        if (!LAST && wrap[d]) id_q[d] <= '0;
        else                  id_q[d] <= id_q[d] + 1'b1;
      end
    end

    assign id_o[d] = id_q[d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gid_q      <= '0;
      complete_q <= 1'b0;
    end else if (launch_i) begin
      gid_q      <= '0;
      complete_q <= 1'b0;
    end else if (adv_i) begin
      gid_q <= gid_q + 1'b1;
      if (step[NDIM-1] && wrap[NDIM-1]) complete_q <= 1'b1;
    end
  end

  assign gid_o      = gid_q;
  assign complete_o = complete_q;
endmodule

// File: rtl/wg_dispatch_seq.sv
module wg_dispatch_seq
  import wg_seq_pkg::*;
#(
  parameter int SIZE_W = 16,
  localparam int TOT_W = NDIM * SIZE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        launch_i,
  input  logic [NDIM-1:0][SIZE_W-1:0] grid_size_i,
  input  logic [NDIM-1:0][SIZE_W-1:0] wg_size_i,
  input  logic                        dispatch_i,
  input  logic                        wg_done_i,
  output logic                        ready_o,
  output logic [NDIM-1:0][SIZE_W-1:0] wg_id_o,
  output logic [TOT_W-1:0]            global_id_o,
  output logic [NDIM-1:0][SIZE_W-1:0] wg_count_o,
  output logic [TOT_W-1:0]            total_wg_o,
  output logic                        dispatch_complete_o,
  output logic [TOT_W-1:0]            completed_o,
  output logic                        all_done_o
);
  logic             adv;
  logic [TOT_W-1:0] completed_q;

  wg_count_calc #(.SIZE_W(SIZE_W)) u_calc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch_i),
    .grid_size_i(grid_size_i),
    .wg_size_i  (wg_size_i),
    .count_o    (wg_count_o),
    .total_o    (total_wg_o),
    .ready_o    (ready_o)
  );

  assign adv = dispatch_i & ready_o & ~dispatch_complete_o & ~launch_i;

  wg_id_walker #(.SIZE_W(SIZE_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch_i),
    .adv_i     (adv),
    .count_i   (wg_count_o),
    .id_o      (wg_id_o),
    .gid_o     (global_id_o),
    .complete_o(dispatch_complete_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        completed_q <= '0;
    else if (launch_i)  completed_q <= '0;
    else if (wg_done_i) completed_q <= completed_q + 1'b1;
  end

  assign completed_o = completed_q;
  assign all_done_o  = dispatch_complete_o & (completed_q == total_wg_o);
endmodule

// File: rtl/wg_dispatch_seq_chk.sv
module wg_dispatch_seq_chk
  import wg_seq_pkg::*;
#(
  parameter int SIZE_W = 16,
  localparam int TOT_W = NDIM * SIZE_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        launch_i,
  input logic                        dispatch_i,
  input logic                        wg_done_i,
  input logic                        ready_o,
  input logic [NDIM-1:0][SIZE_W-1:0] wg_id_o,
  input logic [TOT_W-1:0]            global_id_o,
  input logic                        dispatch_complete_o,
  input logic [TOT_W-1:0]            completed_o,
  input logic                        all_done_o
);
  assert_launch_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (global_id_o == '0 && completed_o == '0 && !dispatch_complete_o && !ready_o));

  assert_not_ready_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !launch_i) |=> $stable(global_id_o) && $stable(wg_id_o));

  assert_global_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_i && ready_o && !dispatch_complete_o && !launch_i)
      |=> global_id_o == $past(global_id_o) + 1'b1);

  assert_sticky_complete_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_complete_o && !launch_i) |=> dispatch_complete_o);

  assert_ignore_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_complete_o && !launch_i) |=> $stable(wg_id_o) && $stable(global_id_o));

  assert_done_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wg_done_i && !launch_i) |=> completed_o == $past(completed_o) + 1'b1);

  assert_all_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |-> dispatch_complete_o);
endmodule

bind wg_dispatch_seq wg_dispatch_seq_chk #(.SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/sim_wg_dispatch_seq.sv
`timescale 1ns/1ps
module sim_wg_dispatch_seq;
  localparam int W  = 6;
  localparam int TW = 3 * W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic launch_i = 1'b0, dispatch_i = 1'b0, wg_done_i = 1'b0;
  logic [2:0][W-1:0] grid_size_i = '0, wg_size_i = '0;
  logic ready_o, dispatch_complete_o, all_done_o;
  logic [2:0][W-1:0] wg_id_o, wg_count_o;
  logic [TW-1:0] global_id_o, total_wg_o, completed_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  wg_dispatch_seq #(.SIZE_W(W)) u0 (.*);

  int pg [5] = '{1, 5, 6, 4, 13};
  int pw [5] = '{1, 2, 3, 5, 4};

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_launch(int gx, int gy, int gz, int wx, int wy, int wz);
    @(negedge clk_i);
    grid_size_i = {W'(gz), W'(gy), W'(gx)};
    wg_size_i   = {W'(wz), W'(wy), W'(wx)};
    launch_i = 1'b1;
    @(negedge clk_i);
    launch_i = 1'b0;
    chk("R3 ready low after launch", ready_o, 0);
    chk("R4/R11 global cleared", global_id_o, 0);
    chk("R4/R11 completed cleared", completed_o, 0);
    chk("R4/R11 complete cleared", dispatch_complete_o, 0);
    chk("R4/R11 ids cleared", wg_id_o, 0);
    // dispatch while not ready must be ignored
    dispatch_i = 1'b1;
    @(negedge clk_i);
    dispatch_i = 1'b0;
    chk("R3 dispatch ignored while not ready", global_id_o, 0);
    for (int i = 0; i < 100 && !ready_o; i++) @(negedge clk_i);
    chk("R3 ready reached", ready_o, 1);
  endtask

  task automatic pulse_dispatch();
    dispatch_i = 1'b1;
    @(negedge clk_i);
    dispatch_i = 1'b0;
  endtask

  task automatic pulse_done();
    wg_done_i = 1'b1;
    @(negedge clk_i);
    wg_done_i = 1'b0;
  endtask

  task automatic run_cfg(int gx, int gy, int gz, int wx, int wy, int wz);
    int n [3];
    int tot, x, y, z, g;
    bit dn;
    do_launch(gx, gy, gz, wx, wy, wz);
    n[0] = (gx + wx - 1) / wx;
    n[1] = (gy + wy - 1) / wy;
    n[2] = (gz + wz - 1) / wz;
    tot = n[0] * n[1] * n[2];
    for (int d = 0; d < 3; d++) chk("R1 axis count", wg_count_o[d], n[d]);
    chk("R2 total", total_wg_o, tot);
    x = 0; y = 0; z = 0; g = 0; dn = 0;
    while (!dn) begin
      chk("R5/R6 x id", wg_id_o[0], x);
      chk("R6 y id", wg_id_o[1], y);
      chk("R6 z id", wg_id_o[2], z);
      chk("R5 global id", global_id_o, g);
      chk("R7 not yet complete", dispatch_complete_o, 0);
      pulse_dispatch();
      x++; g++;
      if (x * wx >= gx) begin
        x = 0; y++;
        if (y * wy >= gy) begin
          y = 0; z++;
          if (z * wz >= gz) dn = 1;
        end
      end
    end
    chk("R7 complete set", dispatch_complete_o, 1);
    chk("R7 final z", wg_id_o[2], z);
    chk("R5 final global", global_id_o, tot);
    pulse_dispatch();
    pulse_dispatch();
    chk("R8 global held", global_id_o, tot);
    chk("R8 ids held", wg_id_o, {W'(z), W'(0), W'(0)});
    chk("R7 still complete", dispatch_complete_o, 1);
    for (int i = 0; i < tot; i++) begin
      chk("R10 not all done early", all_done_o, 0);
      pulse_done();
      chk("R9 completed count", completed_o, i + 1);
    end
    chk("R10 all done", all_done_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R4 reset ready", ready_o, 0);
    chk("R4 reset global", global_id_o, 0);
    chk("R4 reset ids", wg_id_o, 0);
    chk("R4 reset complete", dispatch_complete_o, 0);
    chk("R4 reset completed", completed_o, 0);
    chk("R10 reset all_done", all_done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          run_cfg(pg[a], pg[b], pg[c], pw[a], pw[b], pw[c]);
    // R11: relaunch in the middle of a walk
    do_launch(13, 5, 6, 4, 2, 3);
    repeat (5) pulse_dispatch();
    pulse_done();
    chk("R11 walk in progress", global_id_o, 5);
    run_cfg(6, 13, 5, 3, 4, 2);
    run_cfg(63, 1, 1, 63, 1, 1);
    run_cfg(63, 2, 1, 62, 1, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule